// File: doc/BRIEF.md
# Two-Bank Interrupt Cause Collector with Per-Line Select View

The block gathers interrupt events into two cause banks, a primary bank and a secondary bank. Each event input is a single-cycle pulse, and the block latches it into a sticky cause bit. Each bit stays set until software clears it over a small register bus.

Two interrupt output lines, line 0 and line 1, each have their own pair of enable masks, one for each bank. A line's output is active low. It asserts whenever any enabled cause bit for that line is set.

The block computes three summary flags and shows them inside the primary cause word. For each line it also offers a select word. The select word shows whichever bank holds enabled, active bits for that line, with the primary bank winning. A flag in the select word marks the case where both banks are active. An interrupt handler can therefore do one read in place of two.

The bus is a single-cycle write port plus a combinational read port. Word addresses: 0 primary cause, 1 secondary cause, 2 line-0 primary mask, 3 line-0 secondary mask, 4 line-1 primary mask, 5 line-1 secondary mask, 6 line-0 select, 7 line-1 select.

Top module: `irq_dual_bank`

## Requirements
- R1: An event pulse on `ev_pri[i]` for i in 1..29, or on `ev_sec[i]` for i in 0..31, sets cause bit i of that bank on the next clock edge. Primary event inputs 0, 30 and 31 are ignored.
- R2: Writing address 0 or 1 clears each cause bit whose data bit is 0 and leaves bits written with 1 unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R3: Bit 0 of the primary cause word reads 1 exactly when any stored cause bit in either bank is set, regardless of the masks.
- R4: Bit 30 (line 0) and bit 31 (line 1) of the primary cause word read 1 exactly when some stored cause bit ANDed with that line's mask for its bank is nonzero. Bits 0, 30 and 31 never take part in any of these ORs.
- R5: The four mask words (addresses 2..5) are 32-bit read/write and reset to zero.
- R6: When only the secondary bank has enabled active bits for a line, that line's select word is bit 31 = 0, bit 30 = 1, and bits 29:0 = secondary cause bits 29:0.
- R7: When both banks have enabled active bits for a line, its select word is bit 31 = 1, bit 30 = 0, and bits 29:0 = bits 29:0 of the primary cause word as read.
- R8: When only the primary bank has enabled active bits for a line, its select word is bit 31 = 0, bit 30 = 0, and bits 29:0 = bits 29:0 of the primary cause word as read.
- R9: When neither bank has enabled active bits for a line, its select word reads zero.
- R10: `irq_n[k]` is the registered inverse of line k's masked summary. It changes one clock after the cause or mask change and is 1 in reset.
- R11: After reset both cause banks read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pri | input | 32 | Primary bank event pulses |
| ev_sec | input | 32 | Secondary bank event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_n | output | 2 | Active-low interrupt lines 0 and 1 |

## Verification
A cause bit that is lost or stuck shows up at once, in the same cycle, in the cause word read and in both select words. One clock later it also shows up on the affected interrupt line.

A wrong mask state or a wrong bank priority changes the select flags in bits 30 and 31 and the mirrored low bits, and those are read directly. The bench sweeps every combination of primary/secondary activity and mask enables on both lines, moving the bit position on each step. It compares every readable word and both lines against an arithmetic model of the banks.

// File: rtl/irq_dual_bank_pkg.sv
package irq_dual_bank_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int N_LINES = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Summary flag positions inside the primary cause word
    localparam int POS_RAW   = 0;
    localparam int POS_LINE0 = 30;
    localparam int POS_LINE1 = 31;

    // Primary bank stores only bits 29:1; the rest are computed flags
    localparam word_t PRI_KEEP = 32'h3FFF_FFFE;
    localparam word_t SEC_KEEP = 32'hFFFF_FFFF;

    localparam addr_t ADR_PRI   = 3'd0;
    localparam addr_t ADR_SEC   = 3'd1;
    localparam addr_t ADR_MASK0 = 3'd2;  // line k primary mask at 2+2k, secondary at 3+2k
    localparam addr_t ADR_SEL0  = 3'd6;
    localparam addr_t ADR_SEL1  = 3'd7;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_dual_bank_pkg::*;
#(
    parameter word_t KEEP = SEC_KEEP
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t ev,
    input  logic  clr_en,
    input  word_t clr_data,
    output word_t cause_q
);
    typedef struct packed {
        word_t bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        word_t hold;
        hold = clr_en ? (st_q.bits & clr_data) : st_q.bits;
        st_d.bits = (hold | ev) & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_q = st_q.bits;
endmodule

// File: rtl/irq_line_view.sv
module irq_line_view
    import irq_dual_bank_pkg::*;
(
    input  word_t pri_q,
    input  word_t sec_q,
    input  word_t pri_word,
    input  word_t pri_mask,
    input  word_t sec_mask,
    output logic  line_sum,
    output word_t sel_word
);
    logic pri_act, sec_act;

    always_comb begin
        pri_act  = |(pri_q & pri_mask & PRI_KEEP);
        sec_act  = |(sec_q & sec_mask);
        line_sum = pri_act | sec_act;
        if (pri_act)      sel_word = {sec_act, 1'b0, pri_word[29:0]};
        else if (sec_act) sel_word = {1'b0, 1'b1, sec_q[29:0]};
        else              sel_word = '0;
    end
endmodule

// File: rtl/irq_dual_bank.sv
module irq_dual_bank
    import irq_dual_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ev_pri,
    input  logic [31:0] ev_sec,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [1:0]  irq_n
);
    typedef struct packed {
        logic [N_LINES-1:0][WORD_W-1:0] pmask;
        logic [N_LINES-1:0][WORD_W-1:0] smask;
        logic [N_LINES-1:0]             irq_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    word_t pri_q, sec_q, pri_word;
    logic  raw_sum;
    logic  [N_LINES-1:0] line_sum;
    word_t sel_word [N_LINES];

    irq_cause_bank #(.KEEP(PRI_KEEP)) u_pri (
        .clk(clk), .rst_n(rst_n), .ev(ev_pri),
        .clr_en(wr_en && wr_addr == ADR_PRI), .clr_data(wr_data),
        .cause_q(pri_q)
    );

    irq_cause_bank #(.KEEP(SEC_KEEP)) u_sec (
        .clk(clk), .rst_n(rst_n), .ev(ev_sec),
        .clr_en(wr_en && wr_addr == ADR_SEC), .clr_data(wr_data),
        .cause_q(sec_q)
    );

    assign raw_sum  = (|pri_q) | (|sec_q);
    assign pri_word = {line_sum[1], line_sum[0], pri_q[29:1], raw_sum};

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        irq_line_view u_view (
            .pri_q(pri_q), .sec_q(sec_q), .pri_word(pri_word),
            .pri_mask(ctl_q.pmask[k]), .sec_mask(ctl_q.smask[k]),
            .line_sum(line_sum[k]), .sel_word(sel_word[k])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        for (int k = 0; k < N_LINES; k++) begin
            if (wr_en && wr_addr == addr_t'(ADR_MASK0 + 2*k))
                ctl_d.pmask[k] = wr_data;
            if (wr_en && wr_addr == addr_t'(ADR_MASK0 + 2*k + 1))
                ctl_d.smask[k] = wr_data;
            ctl_d.irq_n[k] = ~line_sum[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.pmask <= '0;
            ctl_q.smask <= '0;
            ctl_q.irq_n <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (rd_addr)
            ADR_PRI:  rd_data = pri_word;
            ADR_SEC:  rd_data = sec_q;
            3'd2:     rd_data = ctl_q.pmask[0];
            3'd3:     rd_data = ctl_q.smask[0];
            3'd4:     rd_data = ctl_q.pmask[1];
            3'd5:     rd_data = ctl_q.smask[1];
            ADR_SEL0: rd_data = sel_word[0];
            ADR_SEL1: rd_data = sel_word[1];
            default:  rd_data = '0;
        endcase
    end

    assign irq_n = ctl_q.irq_n;
endmodule

// File: rtl/irq_dual_bank_chk.sv
module irq_dual_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ev_pri,
    input logic [31:0] ev_sec,
    input logic [31:0] pri_q,
    input logic [31:0] sec_q,
    input logic        raw_sum,
    input logic [1:0]  line_sum,
    input logic [31:0] sel0,
    input logic [31:0] sel1,
    input logic [1:0]  irq_n
);
    // R1 / R2: an event pulse is stored on the next edge, even against a clear
    a_r1_pri_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pri_q & $past(ev_pri & 32'h3FFF_FFFE)) == $past(ev_pri & 32'h3FFF_FFFE)));
    a_r2_sec_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sec_q & $past(ev_sec)) == $past(ev_sec)));
    // R1: summary positions never hold stored state
    a_r1_pri_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_q[0] == 1'b0) && (pri_q[31:30] == 2'b00));
    // R4: a masked summary implies the unmasked one
    a_r4_line0_raw: assert property (@(posedge clk) disable iff (!rst_n)
        line_sum[0] |-> raw_sum);
    a_r4_line1_raw: assert property (@(posedge clk) disable iff (!rst_n)
        line_sum[1] |-> raw_sum);
    // R6 / R7: bank flag and both-active flag are never set together
    a_r7_sel0_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel0[31] && sel0[30]));
    a_r7_sel1_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel1[31] && sel1[30]));
    // R9: idle line shows an empty select word
    a_r9_sel0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !line_sum[0] |-> (sel0 == 32'h0));
    a_r9_sel1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !line_sum[1] |-> (sel1 == 32'h0));
    // R10: each output pin follows its summary one cycle later
    a_r10_irq0: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n[0] == !$past(line_sum[0])));
    a_r10_irq1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n[1] == !$past(line_sum[1])));
endmodule

bind irq_dual_bank irq_dual_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_pri(ev_pri), .ev_sec(ev_sec),
    .pri_q(pri_q), .sec_q(sec_q), .raw_sum(raw_sum), .line_sum(line_sum),
    .sel0(sel_word[0]), .sel1(sel_word[1]), .irq_n(irq_n)
);

// File: tb/irq_dual_bank_bench.sv
module irq_dual_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ev_pri = '0, ev_sec = '0, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  irq_n;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_pri = '0, m_sec = '0;
    logic [31:0] m_pm [2];
    logic [31:0] m_sm [2];

    irq_dual_bank u_irq_dual_bank (
        .clk(clk), .rst_n(rst_n), .ev_pri(ev_pri), .ev_sec(ev_sec),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    function automatic logic m_line(int k);
        return ((m_pri & m_pm[k]) != 0) || ((m_sec & m_sm[k]) != 0);
    endfunction

    function automatic logic [31:0] m_priword();
        logic [31:0] w;
        w = m_pri;
        w[0]  = (m_pri != 0) || (m_sec != 0);
        w[30] = m_line(0);
        w[31] = m_line(1);
        return w;
    endfunction

    function automatic logic [31:0] m_sel(int k);
        logic pa, sa;
        pa = (m_pri & m_pm[k]) != 0;
        sa = (m_sec & m_sm[k]) != 0;
        if (pa) return {sa, 1'b0, m_priword()[29:0]};
        if (sa) return {2'b01, m_sec[29:0]};
        return 32'h0;
    endfunction

    function automatic logic [31:0] m_read(int a);
        case (a)
            0: return m_priword();
            1: return m_sec;
            2: return m_pm[0];
            3: return m_sm[0];
            4: return m_pm[1];
            5: return m_sm[1];
            6: return m_sel(0);
            default: return m_sel(1);
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(string req, int a);
        rd_addr = 3'(a);
        #1;
        check(req, rd_data, m_read(a));
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < 8; a++) read_chk(req, a);
    endtask

    // one cycle: drive at negedge, update model after the edge
    task automatic cyc(logic we, int a, logic [31:0] d, logic [31:0] ep, logic [31:0] es);
        @(negedge clk);
        wr_en = we; wr_addr = 3'(a); wr_data = d; ev_pri = ep; ev_sec = es;
        @(posedge clk);
        #1;
        if (we && a == 0) m_pri = m_pri & d;
        if (we && a == 1) m_sec = m_sec & d;
        if (we && a == 2) m_pm[0] = d;
        if (we && a == 3) m_sm[0] = d;
        if (we && a == 4) m_pm[1] = d;
        if (we && a == 5) m_sm[1] = d;
        m_pri = (m_pri | ep) & 32'h3FFF_FFFE;
        m_sec = m_sec | es;
        @(negedge clk);
        wr_en = 1'b0; ev_pri = '0; ev_sec = '0;
    endtask

    task automatic irq_chk(string req);
        check(req, {30'd0, irq_n}, {30'd0, ~m_line(1), ~m_line(0)});
    endtask

    initial begin
        m_pm[0] = '0; m_pm[1] = '0; m_sm[0] = '0; m_sm[1] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R5, R11, R10: reset values
        read_all("R11/R5 reset");
        check("R10 reset irq", {30'd0, irq_n}, 32'h3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: ignored primary inputs 0,30,31; high bits 30,31 stored
        cyc(1'b0, 0, 0, 32'hC000_0001, 32'hC000_0000);
        read_chk("R1 pri reserved ignored", 0);
        read_chk("R1 sec top bits", 1);
        read_chk("R3 raw from sec only", 0);
        // R9: no masks -> select words zero, lines idle
        read_chk("R9 sel0 masked", 6);
        read_chk("R9 sel1 masked", 7);
        irq_chk("R10 idle lines");
        cyc(1'b1, 1, 32'h0, 0, 0);

        // R2: write 1 keeps, write 0 clears, event beats clear
        cyc(1'b0, 0, 0, 32'h0000_00F0, 0);
        cyc(1'b1, 0, 32'hFFFF_FF3F, 0, 0);
        read_chk("R2 partial clear", 0);
        cyc(1'b1, 0, 32'h0, 32'h0000_0010, 0);
        read_chk("R2 event wins over clear", 0);
        cyc(1'b1, 1, 32'h0, 0, 32'h8000_0001);
        read_chk("R2 sec event wins over clear", 1);
        cyc(1'b1, 0, 0, 0, 0);
        cyc(1'b1, 1, 0, 0, 0);

        // R10: latency of the line after a mask write
        cyc(1'b0, 1, 0, 0, 32'h0000_0004);
        cyc(1'b1, 3, 32'h0000_0004, 0, 0);
        check("R10 one-cycle latency", {31'd0, irq_n[0]}, 32'h1);
        @(posedge clk); #1;
        irq_chk("R10 asserted after a cycle");
        read_chk("R6 sec only line0", 6);
        cyc(1'b1, 1, 0, 0, 0);
        cyc(1'b1, 3, 0, 0, 0);

        // Sweep: every activity/mask combination on each line, moving bits
        for (int ln = 0; ln < 2; ln++) begin
            for (int p = 0; p < 16; p++) begin
                logic [31:0] pb, sb;
                pb = 32'h1 << (1 + p + 8*ln);
                sb = 32'h1 << ((2*p + ln) % 32);
                cyc(1'b1, 0, 0, 0, 0);
                cyc(1'b1, 1, 0, 0, 0);
                cyc(1'b1, 2 + 2*ln, p[0] ? pb | 32'hC000_0001 : 32'h0, 0, 0);
                cyc(1'b1, 3 + 2*ln, p[1] ? sb : 32'h0, 0, 0);
                cyc(1'b1, 4 - 2*ln, 32'h0000_0300, 0, 0);
                cyc(1'b1, 5 - 2*ln, 32'h0000_0000, 0, 0);
                cyc(1'b0, 0, 0, p[2] ? (pb | 32'h0000_0200) : 32'h0, p[3] ? sb : 32'h0);
                @(posedge clk); #1;
                // R3/R4 in word 0, R6..R9 in select words, R5 in masks
                read_all("R3/R4/R5/R6/R7/R8/R9 sweep");
                irq_chk("R10 sweep");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule